// File: doc/BRIEF.md
# E1 Doubleframe Alignment Hunter

This block receives an E1 line one bit at a time, after line decoding and clock recovery, and finds where each 256-bit frame begins. E1 frames come in pairs. The even frame carries a seven-bit alignment word in its first timeslot. The odd frame carries a service word: its second bit is always one and its third bit is the remote alarm bit. The block slides through the stream one bit at a time. It locks only after it sees an alignment word, then a correct service word, then a second alignment word, in three consecutive frames. Once locked, it keeps checking the alignment word in every even frame. After a run of errored words it drops lock and begins the search again by itself.

When locked, the block provides the bit position within the frame, a frame counter whose lowest bit gives the frame parity, and a flag that marks the counters as trustworthy. Loss of alignment is shown as a level. Regaining alignment gives an optional one-cycle pulse. The block also builds the remote alarm bit for the transmit direction. That bit is set by a manual control, or by an automatic control that follows loss of alignment. In the other direction it tracks the alarm bit sent by the far end. A force input throws away the current alignment and starts a fresh search.

Bits arrive on a valid/ready stream. A bit is taken on any clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low during reset and high from the first clock after reset. The block never applies back-pressure after that, so the source may present a bit on every cycle or leave gaps of any length. Timing inside the block moves only on accepted bits.

Top module: `e1_dframe_align`

## Requirements
- R1: Timeslot 0 bits are received in order bit 1 first through bit 8 last. The alignment word is 0011011 in bits 2..8 of an even frame. The service word has bit 2 = 1. The block declares alignment (`lfa` falls) on the clock that accepts bit 8 of frame n+2, and only when frame n held the alignment word, frame n+1 held a service word with bit 2 = 1, and frame n+2 held the alignment word again.
- R2: If the service word in frame n+1 is wrong, the block does not restart the search until after bit 8 of timeslot 0 of frame n+2. If the second alignment word in frame n+2 is wrong, the search restarts on the next bit. In both cases the word in frame n+2 never serves as a starting candidate, so the earliest new lock is at frame n+6 when frames n+4 and n+6 carry the alignment word.
- R3: While aligned, three alignment words in a row that are in error raise `lfa` on the clock that accepts bit 8 of the third one. A correct word in between resets the count.
- R4: A high `force_resync` on a clock edge raises `lfa` on that edge. While `force_resync` stays high, no alignment word is taken as a candidate. After it drops, the search continues by itself.
- R5: `far_irq` is high for exactly one cycle, on the cycle alignment is declared, and only if `far_irq_en` is high. Otherwise it is low.
- R6: `bit_idx` is the position (0..255) of the last accepted bit. It reads 7 right after alignment is declared, and `frame_cnt` reads 0 for the declaring frame. `cnt_valid` rises on the first bit of the next even frame and is low whenever `lfa` is high.
- R7: `tx_a_bit` is 1 while `auto_ra_en` and `lfa` are both high. When the block is aligned and `manual_ra` is low, `tx_a_bit` is 0.
- R8: `manual_ra` high forces `tx_a_bit` to 1 in any state.
- R9: While aligned, the block samples the alarm bit (bit 3 of odd-frame timeslot 0) at bit 8 of that timeslot. `rx_alarm` follows the sampled value. `ra_irq` pulses for one cycle only when a sample of 1 follows a 0, and `rx_alarm` is 0 while unaligned.
- R10: During reset `lfa` = 1, `far_irq` = 0, `cnt_valid` = 0, `ra_irq` = 0 and `in_ready` = 0.
- R11: `in_ready` is 1 from the first clock after reset. A cycle without an accepted bit leaves `bit_idx` and `frame_cnt` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate or faster clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Source presents a line bit |
| in_ready | output | 1 | Block can take a bit |
| in_bit | input | 1 | Received line bit |
| force_resync | input | 1 | Drop alignment and hold off the search while high |
| far_irq_en | input | 1 | Enables the alignment-regained pulse |
| auto_ra_en | input | 1 | Send remote alarm automatically while unaligned |
| manual_ra | input | 1 | Send remote alarm unconditionally |
| lfa | output | 1 | Loss of frame alignment |
| far_irq | output | 1 | One-cycle pulse on alignment regained |
| cnt_valid | output | 1 | Bit and frame counters are valid |
| bit_idx | output | 8 | Bit position within the frame |
| frame_cnt | output | 4 | Frame counter; bit 0 = 1 for odd frames |
| tx_a_bit | output | 1 | Remote alarm bit for transmit |
| rx_alarm | output | 1 | Alarm bit last received from the far end |
| ra_irq | output | 1 | Pulse when the far-end alarm appears |

## Verification
The hardest case to reach from the ports is the restart rule after a failed candidate. An early restart and the correct late restart both end in lock, and they differ only in which frame the lock lands in. The stimulus therefore sends seven whole frames for each failure pattern: a bad service word, a bad second alignment word, or both. All frames after the failure are valid, and `lfa` is sampled at bit 8 of frames n+2, n+4 and n+6. A premature restart would lock at n+4 and is caught there. Loss of alignment is reached by errored alignment words sent while the block is aligned, with a correct word placed between the errors to show that the count resets.

// File: rtl/e1dfa_pkg.sv
package e1dfa_pkg;
  typedef enum logic [2:0] {
    ST_HUNT,
    ST_SVC,
    ST_SKIP,
    ST_FAS2,
    ST_SYNC
  } align_st_t;

  // seven-bit alignment word, bits 2..8 of timeslot 0, first-received bit is MSB
  localparam logic [6:0] ALIGN_WORD = 7'b0011011;
  localparam int         TAIL_W     = 7;
  localparam int         TS0_BITS   = 8;
endpackage

// File: rtl/e1dfa_timebase.sv
module e1dfa_timebase
  import e1dfa_pkg::*;
#(
  parameter int FRAME_BITS = 256,
  parameter int FRM_W      = 4,
  localparam int BIT_W     = $clog2(FRAME_BITS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              bit_in,
  input  logic              phase_load,
  input  logic              frame_clr,
  output logic [TAIL_W-1:0] tail,
  output logic              ts0_end,
  output logic              frame_wrap,
  output logic [BIT_W-1:0]  bit_idx,
  output logic [FRM_W-1:0]  frame_cnt
);
  localparam logic [BIT_W-1:0] LAST_IDX = BIT_W'(FRAME_BITS - 1);
  localparam logic [BIT_W-1:0] TS0_LAST = BIT_W'(TS0_BITS - 1);

  logic [TAIL_W-2:0] hist_q;
  logic [BIT_W-1:0]  idx_inc;

  // window of the newest seven bits including the one being accepted now
  assign tail       = {hist_q, bit_in};
  assign idx_inc    = (bit_idx == LAST_IDX) ? '0 : bit_idx + 1'b1;
  assign ts0_end    = take && (idx_inc == TS0_LAST);
  assign frame_wrap = take && (bit_idx == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q    <= '0;
      bit_idx   <= '0;
      frame_cnt <= '0;
    end else begin
      if (take) begin
        hist_q  <= tail[TAIL_W-2:0];
        bit_idx <= phase_load ? TS0_LAST : idx_inc;
      end
      if (frame_clr)
        frame_cnt <= '0;
      else if (frame_wrap)
        frame_cnt <= frame_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/e1dfa_fsm.sv
module e1dfa_fsm
  import e1dfa_pkg::*;
#(
  parameter int LOSS_LIMIT = 3,
  localparam int LOSS_W    = $clog2(LOSS_LIMIT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              force_resync,
  input  logic              far_irq_en,
  input  logic [TAIL_W-1:0] tail,
  input  logic              ts0_end,
  input  logic              frame_wrap,
  input  logic              odd_frame,
  output logic              phase_load,
  output logic              frame_clr,
  output logic              lfa,
  output logic              far_irq,
  output logic              cnt_valid,
  output logic              a_strobe
);
  localparam logic [LOSS_W-1:0] LOSS_LAST = LOSS_W'(LOSS_LIMIT - 1);

  align_st_t         st_q, st_d;
  logic [LOSS_W-1:0] err_q, err_d;
  logic              word_hit;
  logic              svc_ok;

  assign word_hit = (tail == ALIGN_WORD);
  assign svc_ok   = tail[TAIL_W-1];
  assign lfa      = (st_q != ST_SYNC);
  assign a_strobe = (st_q == ST_SYNC) && ts0_end && odd_frame;

  always_comb begin
    st_d       = st_q;
    err_d      = err_q;
    phase_load = 1'b0;
    frame_clr  = 1'b0;
    unique case (st_q)
      ST_HUNT: begin
        if (take && word_hit && !force_resync) begin
          phase_load = 1'b1;
          st_d       = ST_SVC;
        end
      end
      ST_SVC: begin
        if (ts0_end) st_d = svc_ok ? ST_FAS2 : ST_SKIP;
      end
      ST_SKIP: begin
        if (ts0_end) st_d = ST_HUNT;
      end
      ST_FAS2: begin
        if (ts0_end) begin
          if (word_hit) begin
            st_d      = ST_SYNC;
            frame_clr = 1'b1;
            err_d     = '0;
          end else begin
            st_d = ST_HUNT;
          end
        end
      end
      ST_SYNC: begin
        if (ts0_end && !odd_frame) begin
          if (word_hit) begin
            err_d = '0;
          end else if (err_q == LOSS_LAST) begin
            err_d = '0;
            st_d  = ST_HUNT;
          end else begin
            err_d = err_q + 1'b1;
          end
        end
      end
      default: st_d = ST_HUNT;
    endcase
    if (force_resync) begin
      st_d       = ST_HUNT;
      phase_load = 1'b0;
      frame_clr  = 1'b0;
      err_d      = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_HUNT;
      err_q     <= '0;
      far_irq   <= 1'b0;
      cnt_valid <= 1'b0;
    end else begin
      st_q    <= st_d;
      err_q   <= err_d;
      far_irq <= far_irq_en && (st_d == ST_SYNC) && (st_q != ST_SYNC);
      if (st_d != ST_SYNC)
        cnt_valid <= 1'b0;
      else if (st_q == ST_SYNC && frame_wrap && odd_frame)
        cnt_valid <= 1'b1;
    end
  end
endmodule

// File: rtl/e1dfa_alarm.sv
module e1dfa_alarm (
  input  logic clk,
  input  logic rst_n,
  input  logic lfa,
  input  logic auto_ra_en,
  input  logic manual_ra,
  input  logic a_strobe,
  input  logic a_bit,
  output logic tx_a_bit,
  output logic rx_alarm,
  output logic ra_irq
);
  assign tx_a_bit = manual_ra | (auto_ra_en & lfa);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_alarm <= 1'b0;
      ra_irq   <= 1'b0;
    end else if (lfa) begin
      rx_alarm <= 1'b0;
      ra_irq   <= 1'b0;
    end else begin
      ra_irq <= a_strobe && a_bit && !rx_alarm;
      if (a_strobe) rx_alarm <= a_bit;
    end
  end
endmodule

// File: rtl/e1_dframe_align.sv
module e1_dframe_align
  import e1dfa_pkg::*;
#(
  parameter int FRAME_BITS = 256,
  parameter int FRM_W      = 4,
  parameter int LOSS_LIMIT = 3,
  localparam int IDX_W     = $clog2(FRAME_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_bit,
  input  logic             force_resync,
  input  logic             far_irq_en,
  input  logic             auto_ra_en,
  input  logic             manual_ra,
  output logic             lfa,
  output logic             far_irq,
  output logic             cnt_valid,
  output logic [IDX_W-1:0] bit_idx,
  output logic [FRM_W-1:0] frame_cnt,
  output logic             tx_a_bit,
  output logic             rx_alarm,
  output logic             ra_irq
);
  logic              take;
  logic [TAIL_W-1:0] tail;
  logic              ts0_end, frame_wrap, phase_load, frame_clr, a_strobe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) in_ready <= 1'b0;
    else        in_ready <= 1'b1;
  end

  assign take = in_valid && in_ready;

  e1dfa_timebase #(.FRAME_BITS(FRAME_BITS), .FRM_W(FRM_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .take(take), .bit_in(in_bit),
    .phase_load(phase_load), .frame_clr(frame_clr), .tail(tail),
    .ts0_end(ts0_end), .frame_wrap(frame_wrap),
    .bit_idx(bit_idx), .frame_cnt(frame_cnt)
  );

  e1dfa_fsm #(.LOSS_LIMIT(LOSS_LIMIT)) u_fsm (
    .clk(clk), .rst_n(rst_n), .take(take), .force_resync(force_resync),
    .far_irq_en(far_irq_en), .tail(tail), .ts0_end(ts0_end),
    .frame_wrap(frame_wrap), .odd_frame(frame_cnt[0]),
    .phase_load(phase_load), .frame_clr(frame_clr), .lfa(lfa),
    .far_irq(far_irq), .cnt_valid(cnt_valid), .a_strobe(a_strobe)
  );

  // alarm bit is bit 3 of timeslot 0, i.e. five bits before bit 8
  e1dfa_alarm u_alarm (
    .clk(clk), .rst_n(rst_n), .lfa(lfa), .auto_ra_en(auto_ra_en),
    .manual_ra(manual_ra), .a_strobe(a_strobe), .a_bit(tail[TAIL_W-2]),
    .tx_a_bit(tx_a_bit), .rx_alarm(rx_alarm), .ra_irq(ra_irq)
  );
endmodule

// File: rtl/e1dfa_chk.sv
module e1dfa_chk #(
  parameter int IDX_W = 8,
  parameter int FRM_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             force_resync,
  input logic             lfa,
  input logic             far_irq,
  input logic             cnt_valid,
  input logic [IDX_W-1:0] bit_idx,
  input logic [FRM_W-1:0] frame_cnt,
  input logic             rx_alarm,
  input logic             ra_irq
);
  // R1
  lock_at_ts0_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lfa) |-> (bit_idx == IDX_W'(7)) && $past(in_valid && in_ready));
  // R3
  loss_needs_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lfa) |-> $past(force_resync || (in_valid && in_ready)));
  // R4
  force_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    force_resync |=> lfa);
  // R5
  far_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    far_irq |=> !far_irq);
  // R5
  far_on_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    far_irq |-> !lfa && $past(lfa));
  // R6
  cnt_valid_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_valid |-> !lfa);
  // R6
  cnt_valid_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cnt_valid) |-> (bit_idx == '0) && !frame_cnt[0]);
  // R9
  ra_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ra_irq |-> rx_alarm && !lfa);
  // R9
  ra_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ra_irq |=> !ra_irq);
  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> $stable(bit_idx) && $stable(frame_cnt));
endmodule

bind e1_dframe_align e1dfa_chk #(.IDX_W(IDX_W), .FRM_W(FRM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .force_resync(force_resync), .lfa(lfa), .far_irq(far_irq),
  .cnt_valid(cnt_valid), .bit_idx(bit_idx), .frame_cnt(frame_cnt),
  .rx_alarm(rx_alarm), .ra_irq(ra_irq)
);

// File: tb/e1_dframe_align_tb.sv
`timescale 1ns/1ps
module e1_dframe_align_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, in_bit = 1'b1, force_resync = 1'b0;
  logic       far_irq_en = 1'b0, auto_ra_en = 1'b1, manual_ra = 1'b0;
  logic       in_ready, lfa, far_irq, cnt_valid, tx_a_bit, rx_alarm, ra_irq;
  logic [7:0] bit_idx;
  logic [3:0] frame_cnt;
  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  e1_dframe_align u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_bit(in_bit), .force_resync(force_resync), .far_irq_en(far_irq_en),
    .auto_ra_en(auto_ra_en), .manual_ra(manual_ra), .lfa(lfa),
    .far_irq(far_irq), .cnt_valid(cnt_valid), .bit_idx(bit_idx),
    .frame_cnt(frame_cnt), .tx_a_bit(tx_a_bit), .rx_alarm(rx_alarm),
    .ra_irq(ra_irq)
  );

  // vector fields: [3] service word ok, [2] second alignment word ok,
  // [1] recovery pulse enabled, [0] lock expected at frame n+6 instead of n+2
  localparam logic [3:0] VECS [0:4] = '{4'b1110, 4'b1100, 4'b0111, 4'b1011, 4'b0001};

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    in_valid = 1'b1;
    in_bit   = b;
    @(posedge clk);
    #2;
    in_valid = 1'b0;
  endtask

  // even: alignment word (good) or a corrupted one; odd: service word with alarm bit
  task automatic send_frame(input bit even, input bit ok, input bit a, input int lo, input int hi);
    logic [7:0] ts0;
    ts0 = even ? (ok ? 8'b1001_1011 : 8'b1111_1011) : {1'b1, ok, a, 5'b11111};
    for (int i = lo; i <= hi; i++) send_bit(i < 8 ? ts0[7-i] : 1'b1);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic lock_up();
    send_frame(1, 1, 0, 0, 255);
    send_frame(0, 1, 0, 0, 255);
    send_frame(1, 1, 0, 0, 7);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    @(posedge clk); #2;
    idle(2);
    // R10 reset state
    chk("R10 lfa in reset", lfa, 1);
    chk("R10 far_irq in reset", far_irq, 0);
    chk("R10 cnt_valid in reset", cnt_valid, 0);
    chk("R10 ra_irq in reset", ra_irq, 0);
    chk("R10 in_ready in reset", in_ready, 0);
    chk("R7 auto alarm in reset", tx_a_bit, 1);
    rst_n = 1'b1;
    idle(2);
    chk("R11 in_ready after reset", in_ready, 1);

    // table walk: lock and restart rules
    foreach (VECS[v]) begin
      logic svc, fas2, irq;
      int lock_k;
      svc    = VECS[v][3];
      fas2   = VECS[v][2];
      irq    = VECS[v][1];
      lock_k = VECS[v][0] ? 6 : 2;
      far_irq_en   = irq;
      force_resync = 1'b1;
      idle(1);
      force_resync = 1'b0;
      for (int p = 0; p < 37 + v; p++) send_bit(1'b1);
      for (int k = 0; k < 7; k++) begin
        bit even, ok;
        even = (k % 2 == 0);
        ok   = even ? ((k == 2) ? fas2 : 1'b1) : ((k == 1) ? svc : 1'b1);
        send_frame(even, ok, 0, 0, 7);
        if (even && k >= 2) begin
          chk($sformatf("R1 R2 vec%0d lfa at frame n+%0d", v, k), lfa, (k < lock_k) ? 1 : 0);
          chk($sformatf("R5 vec%0d far_irq at frame n+%0d", v, k), far_irq,
              (k == lock_k) ? int'(irq) : 0);
          if (k == lock_k) begin
            chk("R6 bit_idx at lock", bit_idx, 7);
            chk("R6 frame_cnt at lock", frame_cnt, 0);
            send_bit(1'b1);
            chk("R5 far_irq one cycle", far_irq, 0);
            send_frame(even, ok, 0, 9, 255);
          end else begin
            send_frame(even, ok, 0, 8, 255);
          end
        end else begin
          send_frame(even, ok, 0, 8, 255);
        end
      end
    end

    // R6 counters become valid at the next doubleframe
    chk("R6 cnt_valid before doubleframe", cnt_valid, 0);
    send_frame(0, 1, 0, 0, 255);
    chk("R6 cnt_valid end of odd frame", cnt_valid, 0);
    chk("R6 frame_cnt odd", frame_cnt, 1);
    chk("R6 bit_idx last", bit_idx, 255);
    send_frame(1, 1, 0, 0, 0);
    chk("R6 cnt_valid at doubleframe start", cnt_valid, 1);
    chk("R6 bit_idx wrap", bit_idx, 0);
    chk("R6 frame_cnt even", frame_cnt, 2);
    send_frame(1, 1, 0, 1, 255);

    // R11 gaps on the stream
    idle(5);
    chk("R11 bit_idx held over gap", bit_idx, 255);
    chk("R11 frame_cnt held over gap", frame_cnt, 2);

    // R7 R8 transmit alarm bit
    chk("R7 no alarm when aligned", tx_a_bit, 0);
    manual_ra = 1'b1; #1;
    chk("R8 manual alarm aligned", tx_a_bit, 1);
    manual_ra = 1'b0; #1;

    // R9 far-end alarm
    send_frame(0, 1, 1, 0, 7);
    chk("R9 ra_irq on rising alarm", ra_irq, 1);
    chk("R9 rx_alarm set", rx_alarm, 1);
    send_frame(0, 1, 1, 8, 8);
    chk("R9 ra_irq single cycle", ra_irq, 0);
    send_frame(0, 1, 1, 9, 255);
    send_frame(1, 1, 0, 0, 255);
    send_frame(0, 1, 1, 0, 7);
    chk("R9 no pulse on repeated alarm", ra_irq, 0);
    send_frame(0, 1, 1, 8, 255);
    send_frame(1, 1, 0, 0, 255);
    send_frame(0, 1, 0, 0, 7);
    chk("R9 rx_alarm cleared", rx_alarm, 0);
    send_frame(0, 1, 0, 8, 255);

    // R3 loss of alignment
    send_frame(1, 0, 0, 0, 255);
    send_frame(0, 1, 0, 0, 255);
    send_frame(1, 0, 0, 0, 7);
    chk("R3 two errors keep lock", lfa, 0);
    send_frame(1, 0, 0, 8, 255);
    send_frame(0, 1, 0, 0, 255);
    send_frame(1, 1, 0, 0, 255);
    send_frame(0, 1, 0, 0, 255);
    send_frame(1, 0, 0, 0, 7);
    chk("R3 good word reset count", lfa, 0);
    send_frame(1, 0, 0, 8, 255);
    send_frame(0, 1, 0, 0, 255);
    send_frame(1, 0, 0, 0, 255);
    send_frame(0, 1, 0, 0, 255);
    send_frame(1, 0, 0, 0, 7);
    chk("R3 third error drops lock", lfa, 1);
    chk("R7 auto alarm on loss", tx_a_bit, 1);
    chk("R6 cnt_valid dropped", cnt_valid, 0);
    auto_ra_en = 1'b0; #1;
    chk("R7 auto alarm disabled", tx_a_bit, 0);
    auto_ra_en = 1'b1;
    send_frame(1, 0, 0, 8, 255);

    // R4 forced resynchronisation
    lock_up();
    chk("R4 relocked before force", lfa, 0);
    send_frame(1, 1, 0, 8, 255);
    force_resync = 1'b1;
    idle(1);
    chk("R4 lfa after force", lfa, 1);
    lock_up();
    chk("R4 no lock while forced", lfa, 1);
    send_frame(1, 1, 0, 8, 255);
    force_resync = 1'b0;
    lock_up();
    chk("R4 search resumes after force", lfa, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule